// File: doc/BRIEF.md
# Multicore Global Control Register Bank

This block is a memory-mapped register bank for a small multiprocessor. It holds system-wide configuration and a set of control registers for each virtual processor. Every access carries a requester ID. The address space is split into three areas. The global area holds the identification registers, the companion base registers and the companion status registers. The local window reaches the requester's own processor registers. The other window reaches the processor registers of whichever processor the requester has selected through its redirect pointer.

The bank owns the relocatable base registers for two companion units, an interrupt controller and a power controller. It drives each unit's decode base address and enable bit. It also exports one exception base vector per processor, taken from that processor's reset-base register. Accesses take one cycle. Read data appears on the cycle after the request.

Address map (byte offsets, 16-bit address):

| Offset | Register |
|--------|----------|
| 0x0000 | global config |
| 0x0008 | self base |
| 0x0030 | revision |
| 0x0080 | interrupt-controller base |
| 0x0088 | power-controller base |
| 0x00D0 | interrupt-controller status |
| 0x00F0 | power-controller status |
| 0x0130 | L2 config |

The local window starts at 0x2000 and the other window at 0x4000. Each window holds three registers at these offsets inside the window:

| Window offset | Register |
|---------------|----------|
| 0x10 | processor config |
| 0x18 | redirect pointer |
| 0x20 | reset base |

Top module: `mcg_regbank`

## Requirements
- R1: While reset is held and right after it, every redirect pointer is 0 and every reset-base register holds 0x00000000_BFC00000. Every exception base output is 0xFFFFFFFF_BFC00000. Both companion base registers, their address outputs and their enable outputs are 0.
- R2: The global config register at 0x0000 reads as 0. The revision register at 0x0030 reads as the REV parameter, default 0x800. The self-base register at 0x0008 reads as SELF_BASE, default 0x1FBF8000. The L2 config register at 0x0130 reads with only bit 20, the cache-bypass bit, set.
- R3: The processor config register at window offset 0x10 reads as NUM_VP-1 in both the local window and the other window.
- R4: Read data appears on rdata_o in the cycle after a read request. In any cycle that does not follow a read, rdata_o is 0.
- R5: The local-window registers at 0x2018 and 0x2020 read and write the register set of the processor named by rid_i.
- R6: The other-window registers at 0x4018 and 0x4020 read and write the register set of the processor named by the requester's redirect pointer.
- R7: A write to a redirect pointer keeps only bits 3:0 of the write data. The whole write is dropped when that masked value is NUM_VP or more.
- R8: A reset-base register stores write data bits 31:12 and clears every other bit. That processor's exception base output equals the stored value sign-extended from bit 31. It changes in the cycle after the write, whichever window made the write.
- R9: A companion base register stores the write data ANDed with its address mask plus bit 0. The interrupt-controller address mask is bits 47:17 and the power-controller address mask is bits 47:15. The stored address field drives the base output and bit 0 drives the enable output. A write made while that companion's present input is low leaves the register unchanged.
- R10: A companion status register at 0x00D0 or 0x00F0 reads as 1 when that companion's present input is high and 0 when it is low.
- R11: A read of an unmapped offset returns 0. A write to an unmapped offset or to a read-only register changes nothing that can be read or observed at the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 64 | Write data |
| rid_i | input | IDW | Requester processor ID |
| rdata_o | output | 64 | Read data, one cycle after the request |
| intc_present_i | input | 1 | Interrupt controller is present |
| pwr_present_i | input | 1 | Power controller is present |
| intc_base_o | output | 64 | Interrupt-controller decode base |
| intc_en_o | output | 1 | Interrupt-controller enable |
| pwr_base_o | output | 64 | Power-controller decode base |
| pwr_en_o | output | 1 | Power-controller enable |
| exc_base_o | output | NUM_VP*64 | Exception base vector for each processor, processor 0 in the lowest 64 bits |

## Verification
The bench goes after the redirect path. It points a requester at another processor, then writes a reset base and a redirect pointer through the other window. A design that resolves the target from the wrong pointer would corrupt the requester's own set, or leave a stale exception vector on the wrong processor.

The bench also writes redirect pointer values that are legal only once their upper bits are masked off, and values at or above the processor count. A design that compares before masking, or that keeps part of a rejected write, would read back a different pointer.

Companion writes are made with the present input both low and high. Writes are also made to read-only and unmapped offsets. Any leak from these writes shows up on the base and enable outputs, or on a later read.

// File: rtl/mcg_pkg.sv
package mcg_pkg;
  localparam int unsigned DW    = 64;
  localparam int unsigned AW    = 16;
  localparam int unsigned WIN_W = 13;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_GCFG,
    SEL_SELF,
    SEL_REV,
    SEL_INTC_BASE,
    SEL_PWR_BASE,
    SEL_INTC_STAT,
    SEL_PWR_STAT,
    SEL_L2,
    SEL_VP_CFG,
    SEL_VP_OTHER,
    SEL_VP_RBASE
  } reg_sel_e;

  localparam logic [AW-1:0] OFS_GCFG      = 16'h0000;
  localparam logic [AW-1:0] OFS_SELF      = 16'h0008;
  localparam logic [AW-1:0] OFS_REV       = 16'h0030;
  localparam logic [AW-1:0] OFS_INTC_BASE = 16'h0080;
  localparam logic [AW-1:0] OFS_PWR_BASE  = 16'h0088;
  localparam logic [AW-1:0] OFS_INTC_STAT = 16'h00D0;
  localparam logic [AW-1:0] OFS_PWR_STAT  = 16'h00F0;
  localparam logic [AW-1:0] OFS_L2        = 16'h0130;

  localparam logic [AW-1:0] WIN_LOC = 16'h2000;
  localparam logic [AW-1:0] WIN_OTH = 16'h4000;

  localparam logic [WIN_W-1:0] OFS_VP_CFG   = 13'h0010;
  localparam logic [WIN_W-1:0] OFS_VP_OTHER = 13'h0018;
  localparam logic [WIN_W-1:0] OFS_VP_RBASE = 13'h0020;

  function automatic logic [DW-1:0] sext32(input logic [31:0] v);
    return {{(DW-32){v[31]}}, v};
  endfunction
endpackage

// File: rtl/mcg_addr_dec.sv
module mcg_addr_dec
  import mcg_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o,
  output logic          oth_o
);
  logic [AW-1:0]    win_base;
  logic [WIN_W-1:0] win_ofs;

  assign win_base = {addr_i[AW-1:WIN_W], {WIN_W{1'b0}}};
  assign win_ofs  = addr_i[WIN_W-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    oth_o = 1'b0;
    if (win_base == WIN_LOC || win_base == WIN_OTH) begin
      oth_o = (win_base == WIN_OTH);
      case (win_ofs)
        OFS_VP_CFG:   sel_o = SEL_VP_CFG;
        OFS_VP_OTHER: sel_o = SEL_VP_OTHER;
        OFS_VP_RBASE: sel_o = SEL_VP_RBASE;
        default:      sel_o = SEL_NONE;
      endcase
    end else begin
      case (addr_i)
        OFS_GCFG:      sel_o = SEL_GCFG;
        OFS_SELF:      sel_o = SEL_SELF;
        OFS_REV:       sel_o = SEL_REV;
        OFS_INTC_BASE: sel_o = SEL_INTC_BASE;
        OFS_PWR_BASE:  sel_o = SEL_PWR_BASE;
        OFS_INTC_STAT: sel_o = SEL_INTC_STAT;
        OFS_PWR_STAT:  sel_o = SEL_PWR_STAT;
        OFS_L2:        sel_o = SEL_L2;
        default:       sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mcg_comp_base.sv
module mcg_comp_base
  import mcg_pkg::*;
#(
  parameter logic [DW-1:0] ADDR_MASK = 64'h0000_FFFF_FFFE_0000,
  parameter int unsigned   EN_BIT    = 0,
  localparam logic [DW-1:0] WR_MASK  = ADDR_MASK | (DW'(1) << EN_BIT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          present_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] base_q_o,
  output logic [DW-1:0] addr_o,
  output logic          en_o
);
  logic [DW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (we_i && present_i) begin
      base_q <= wdata_i & WR_MASK;
    end
  end

  assign base_q_o = base_q;
  assign addr_o   = base_q & ADDR_MASK;
  assign en_o     = base_q[EN_BIT];
endmodule

// File: rtl/mcg_vp_regs.sv
module mcg_vp_regs
  import mcg_pkg::*;
#(
  parameter int unsigned NUM_VP     = 4,
  parameter int unsigned OTHER_W    = 4,
  parameter logic [31:0] RBASE_MASK = 32'hFFFF_F000,
  parameter logic [31:0] RBASE_RST  = 32'hBFC0_0000,
  localparam int unsigned IDW       = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IDW-1:0]       rid_i,
  input  logic                 oth_i,
  input  logic                 other_we_i,
  input  logic                 rbase_we_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [OTHER_W-1:0]   other_rd_o,
  output logic [31:0]          rbase_rd_o,
  output logic [NUM_VP*DW-1:0] exc_base_o
);
  logic [OTHER_W-1:0] other_q [NUM_VP];
  logic [31:0]        rbase_q [NUM_VP];
  logic [IDW-1:0]     tgt;
  logic [OTHER_W-1:0] other_new;
  logic               other_ok;

  // Target set: own ID, or the one the requester points at
  assign tgt       = oth_i ? other_q[rid_i][IDW-1:0] : rid_i;
  assign other_new = wdata_i[OTHER_W-1:0];
  assign other_ok  = 32'(other_new) < 32'(NUM_VP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_VP; i++) begin
        other_q[i] <= '0;
        rbase_q[i] <= RBASE_RST & RBASE_MASK;
      end
    end else begin
      for (int i = 0; i < NUM_VP; i++) begin
        if (tgt == IDW'(i)) begin
          if (other_we_i && other_ok) other_q[i] <= other_new;
          if (rbase_we_i)             rbase_q[i] <= wdata_i[31:0] & RBASE_MASK;
        end
      end
    end
  end

  assign other_rd_o = other_q[tgt];
  assign rbase_rd_o = rbase_q[tgt];

  for (genvar g = 0; g < NUM_VP; g++) begin : g_exc
    assign exc_base_o[g*DW +: DW] = sext32(rbase_q[g] & RBASE_MASK);
  end
endmodule

// File: rtl/mcg_regbank.sv
module mcg_regbank
  import mcg_pkg::*;
#(
  parameter int unsigned   NUM_VP         = 4,
  parameter int unsigned   OTHER_W        = 4,
  parameter logic [DW-1:0] REV            = 64'h800,
  parameter logic [DW-1:0] SELF_BASE      = 64'h1FBF_8000,
  parameter int unsigned   L2_BYPASS_BIT  = 20,
  parameter logic [DW-1:0] INTC_ADDR_MASK = 64'h0000_FFFF_FFFE_0000,
  parameter logic [DW-1:0] PWR_ADDR_MASK  = 64'h0000_FFFF_FFFF_8000,
  parameter int unsigned   COMP_EN_BIT    = 0,
  parameter logic [31:0]   RBASE_MASK     = 32'hFFFF_F000,
  parameter logic [31:0]   RBASE_RST      = 32'hBFC0_0000,
  localparam int unsigned  IDW            = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [IDW-1:0]       rid_i,
  output logic [DW-1:0]        rdata_o,
  input  logic                 intc_present_i,
  input  logic                 pwr_present_i,
  output logic [DW-1:0]        intc_base_o,
  output logic                 intc_en_o,
  output logic [DW-1:0]        pwr_base_o,
  output logic                 pwr_en_o,
  output logic [NUM_VP*DW-1:0] exc_base_o
);
  reg_sel_e           sel;
  logic               oth;
  logic               wr, rd;
  logic [DW-1:0]      intc_q, pwr_q;
  logic [OTHER_W-1:0] other_rd;
  logic [31:0]        rbase_rd;
  logic [DW-1:0]      rd_next, rd_q;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  mcg_addr_dec i_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .oth_o  (oth)
  );

  mcg_comp_base #(
    .ADDR_MASK (INTC_ADDR_MASK),
    .EN_BIT    (COMP_EN_BIT)
  ) i_intc_base (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr && sel == SEL_INTC_BASE),
    .present_i (intc_present_i),
    .wdata_i   (wdata_i),
    .base_q_o  (intc_q),
    .addr_o    (intc_base_o),
    .en_o      (intc_en_o)
  );

  mcg_comp_base #(
    .ADDR_MASK (PWR_ADDR_MASK),
    .EN_BIT    (COMP_EN_BIT)
  ) i_pwr_base (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr && sel == SEL_PWR_BASE),
    .present_i (pwr_present_i),
    .wdata_i   (wdata_i),
    .base_q_o  (pwr_q),
    .addr_o    (pwr_base_o),
    .en_o      (pwr_en_o)
  );

  mcg_vp_regs #(
    .NUM_VP     (NUM_VP),
    .OTHER_W    (OTHER_W),
    .RBASE_MASK (RBASE_MASK),
    .RBASE_RST  (RBASE_RST)
  ) i_vp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rid_i      (rid_i),
    .oth_i      (oth),
    .other_we_i (wr && sel == SEL_VP_OTHER),
    .rbase_we_i (wr && sel == SEL_VP_RBASE),
    .wdata_i    (wdata_i),
    .other_rd_o (other_rd),
    .rbase_rd_o (rbase_rd),
    .exc_base_o (exc_base_o)
  );

  always_comb begin
    case (sel)
      SEL_SELF:      rd_next = SELF_BASE;
      SEL_REV:       rd_next = REV;
      SEL_INTC_BASE: rd_next = intc_q;
      SEL_PWR_BASE:  rd_next = pwr_q;
      SEL_INTC_STAT: rd_next = DW'(intc_present_i);
      SEL_PWR_STAT:  rd_next = DW'(pwr_present_i);
      SEL_L2:        rd_next = DW'(1) << L2_BYPASS_BIT;
      SEL_VP_CFG:    rd_next = DW'(NUM_VP - 1);
      SEL_VP_OTHER:  rd_next = DW'(other_rd);
      SEL_VP_RBASE:  rd_next = DW'(rbase_rd);
      default:       rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd ? rd_next : '0;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/mcg_regbank_chk.sv
module mcg_regbank_chk
  import mcg_pkg::*;
#(
  parameter int unsigned   NUM_VP = 4,
  parameter logic [DW-1:0] REV    = 64'h800
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [AW-1:0]        addr_i,
  input logic [DW-1:0]        rdata_o,
  input logic                 intc_present_i,
  input logic                 pwr_present_i,
  input logic [DW-1:0]        intc_base_o,
  input logic                 intc_en_o,
  input logic [DW-1:0]        pwr_base_o,
  input logic                 pwr_en_o,
  input logic [NUM_VP*DW-1:0] exc_base_o
);
  p_idle_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == '0);

  p_gcfg_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_GCFG) |=> rdata_o == '0);

  p_rev_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_REV) |=> rdata_o == REV);

  p_vp_cfg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i == (WIN_LOC | AW'(OFS_VP_CFG)) ||
                        addr_i == (WIN_OTH | AW'(OFS_VP_CFG))))
    |=> rdata_o == DW'(NUM_VP - 1));

  p_intc_stat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_INTC_STAT)
    |=> rdata_o == DW'($past(intc_present_i)));

  p_pwr_stat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_PWR_STAT)
    |=> rdata_o == DW'($past(pwr_present_i)));

  p_intc_absent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !intc_present_i |=> $stable(intc_base_o) && $stable(intc_en_o));

  p_pwr_absent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_present_i |=> $stable(pwr_base_o) && $stable(pwr_en_o));

  p_exc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(exc_base_o));

  p_comp_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(intc_base_o) && $stable(pwr_base_o));
endmodule

bind mcg_regbank mcg_regbank_chk #(
  .NUM_VP (NUM_VP),
  .REV    (REV)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_i          (req_i),
  .we_i           (we_i),
  .addr_i         (addr_i),
  .rdata_o        (rdata_o),
  .intc_present_i (intc_present_i),
  .pwr_present_i  (pwr_present_i),
  .intc_base_o    (intc_base_o),
  .intc_en_o      (intc_en_o),
  .pwr_base_o     (pwr_base_o),
  .pwr_en_o       (pwr_en_o),
  .exc_base_o     (exc_base_o)
);

// File: tb/test_mcg_regbank.sv
module test_mcg_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int NV         = 4;
  localparam logic [63:0] M_INTC = 64'h0000_FFFF_FFFE_0000;
  localparam logic [63:0] M_PWR  = 64'h0000_FFFF_FFFF_8000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [15:0]       addr = '0;
  logic [63:0]       wdata = '0;
  logic [1:0]        rid = '0;
  logic              intc_pres = 1'b0, pwr_pres = 1'b0;
  logic [63:0]       rdata, intc_base, pwr_base;
  logic              intc_en, pwr_en;
  logic [NV*64-1:0]  exc_base;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] m_rbase [NV];
  logic [3:0]  m_other [NV];
  logic [63:0] m_intc, m_pwr;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcg_regbank i_mcg_regbank (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .req_i          (req),
    .we_i           (we),
    .addr_i         (addr),
    .wdata_i        (wdata),
    .rid_i          (rid),
    .rdata_o        (rdata),
    .intc_present_i (intc_pres),
    .pwr_present_i  (pwr_pres),
    .intc_base_o    (intc_base),
    .intc_en_o      (intc_en),
    .pwr_base_o     (pwr_base),
    .pwr_en_o       (pwr_en),
    .exc_base_o     (exc_base)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  function automatic logic [63:0] m_read(input logic [15:0] a, input logic [1:0] r);
    case (a)
      16'h0000: return 64'h0;
      16'h0008: return 64'h1FBF_8000;
      16'h0030: return 64'h800;
      16'h0080: return m_intc;
      16'h0088: return m_pwr;
      16'h00D0: return {63'b0, intc_pres};
      16'h00F0: return {63'b0, pwr_pres};
      16'h0130: return 64'h0010_0000;
      16'h2010, 16'h4010: return 64'(NV - 1);
      16'h2018: return 64'(m_other[r]);
      16'h4018: return 64'(m_other[m_other[r][1:0]]);
      16'h2020: return m_rbase[r];
      16'h4020: return m_rbase[m_other[r][1:0]];
      default:  return 64'h0;
    endcase
  endfunction

  task automatic m_write(input logic [15:0] a, input logic [63:0] d, input logic [1:0] r);
    logic [1:0] t;
    t = (a[14]) ? m_other[r][1:0] : r;
    case (a)
      16'h0080: if (intc_pres) m_intc = d & (M_INTC | 64'h1);
      16'h0088: if (pwr_pres)  m_pwr  = d & (M_PWR | 64'h1);
      16'h2018, 16'h4018: if (int'(d[3:0]) < NV) m_other[t] = d[3:0];
      16'h2020, 16'h4020: m_rbase[t] = d & 64'h0000_0000_FFFF_F000;
      default: ;
    endcase
  endtask

  function automatic string tag_of(input logic [15:0] a);
    case (a)
      16'h0000, 16'h0008, 16'h0030, 16'h0130: return "R2";
      16'h0080, 16'h0088: return "R9";
      16'h00D0, 16'h00F0: return "R10";
      16'h2010, 16'h4010: return "R3";
      16'h2018, 16'h2020: return "R5";
      16'h4018, 16'h4020: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic cyc(input bit rq, input bit wr, input logic [15:0] a,
                     input logic [63:0] d, input logic [1:0] r);
    logic [63:0] exp_rd;
    string t;
    req = rq; we = wr; addr = a; wdata = d; rid = r;
    @(posedge clk);
    exp_rd = (rq && !wr) ? m_read(a, r) : 64'h0;
    t = (rq && !wr) ? tag_of(a) : "R4";
    if (rq && wr) m_write(a, d, r);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk(t, rdata, exp_rd);
    for (int i = 0; i < NV; i++) chk("R8", exc_base[i*64 +: 64], sx(m_rbase[i]));
    chk("R9", intc_base, m_intc & M_INTC);
    chk("R9", {63'b0, intc_en}, {63'b0, m_intc[0]});
    chk("R9", pwr_base, m_pwr & M_PWR);
    chk("R9", {63'b0, pwr_en}, {63'b0, m_pwr[0]});
  endtask

  task automatic rd_reg(input logic [15:0] a, input logic [1:0] r);
    cyc(1'b1, 1'b0, a, 64'h0, r);
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [63:0] d, input logic [1:0] r);
    cyc(1'b1, 1'b1, a, d, r);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [15:0] alist [16];
    alist = '{16'h0000, 16'h0008, 16'h0030, 16'h0080, 16'h0088, 16'h00D0,
              16'h00F0, 16'h0130, 16'h2010, 16'h2018, 16'h2020, 16'h4010,
              16'h4018, 16'h4020, 16'h0100, 16'h6020};
    for (int i = 0; i < NV; i++) begin
      m_other[i] = '0;
      m_rbase[i] = 64'h0000_0000_BFC0_0000;
    end
    m_intc = '0;
    m_pwr  = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", rdata, 64'h0);
    for (int i = 0; i < NV; i++) chk("R1", exc_base[i*64 +: 64], 64'hFFFF_FFFF_BFC0_0000);
    chk("R1", intc_base, 64'h0);
    chk("R1", {63'b0, pwr_en}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      rd_reg(16'h2018, 2'(i));
      rd_reg(16'h2020, 2'(i));
    end

    // R2 constants, R10 status
    rd_reg(16'h0000, 2'd0);
    rd_reg(16'h0008, 2'd1);
    rd_reg(16'h0030, 2'd2);
    rd_reg(16'h0130, 2'd3);
    rd_reg(16'h00D0, 2'd0);
    intc_pres = 1'b1;
    rd_reg(16'h00D0, 2'd0);
    rd_reg(16'h00F0, 2'd0);
    pwr_pres = 1'b1;
    rd_reg(16'h00F0, 2'd0);

    // R3 both windows; R4 idle cycles
    rd_reg(16'h2010, 2'd0);
    rd_reg(16'h4010, 2'd3);
    cyc(1'b0, 1'b0, 16'h0030, 64'h0, 2'd0);

    // R5 local window, R8 exception vector
    wr_reg(16'h2020, 64'h1234_5678_ABCD_EFFF, 2'd1);
    rd_reg(16'h2020, 2'd1);
    rd_reg(16'h2020, 2'd0);

    // R7 pointer masking and rejection
    wr_reg(16'h2018, 64'h2, 2'd0);
    rd_reg(16'h2018, 2'd0);
    wr_reg(16'h2018, 64'h14, 2'd0);
    rd_reg(16'h2018, 2'd0);
    wr_reg(16'h2018, 64'hF3, 2'd0);
    rd_reg(16'h2018, 2'd0);
    wr_reg(16'h2018, 64'h7, 2'd0);
    rd_reg(16'h2018, 2'd0);

    // R6 other window writes
    wr_reg(16'h4020, 64'h7FFF_F123, 2'd0);
    rd_reg(16'h4020, 2'd0);
    rd_reg(16'h2020, 2'd3);
    wr_reg(16'h4018, 64'h1, 2'd0);
    rd_reg(16'h2018, 2'd3);
    rd_reg(16'h4018, 2'd3);
    rd_reg(16'h2018, 2'd0);

    // R9 companion bases with and without presence
    intc_pres = 1'b0;
    wr_reg(16'h0080, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0);
    rd_reg(16'h0080, 2'd0);
    intc_pres = 1'b1;
    wr_reg(16'h0080, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0);
    rd_reg(16'h0080, 2'd0);
    wr_reg(16'h0088, 64'h0000_1234_5678_9ABC, 2'd2);
    rd_reg(16'h0088, 2'd2);
    pwr_pres = 1'b0;
    wr_reg(16'h0088, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2);
    rd_reg(16'h0088, 2'd2);

    // R11 unmapped and read-only
    wr_reg(16'h0100, 64'hDEAD_BEEF, 2'd0);
    rd_reg(16'h0100, 2'd0);
    wr_reg(16'h0030, 64'h1, 2'd0);
    rd_reg(16'h0030, 2'd0);
    wr_reg(16'h2010, 64'h9, 2'd1);
    rd_reg(16'h2010, 2'd1);
    rd_reg(16'h6000, 2'd0);

    // Mixed traffic
    seed = 32'h1357_9BDF;
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic [63:0] d;
      logic [1:0]  r;
      seed = seed * 32'd1664525 + 32'd1013904223;
      a = alist[seed[27:24]];
      r = seed[21:20];
      intc_pres = seed[17];
      pwr_pres  = seed[16];
      d = {seed, ~seed ^ 32'hA5A5_0F0F};
      if (a[3:0] == 4'h8 && a[13]) d = {59'b0, seed[12:8]};
      if (a[3:0] == 4'h8 && a[14]) d = {59'b0, seed[12:8]};
      cyc(seed[31], seed[30], a, d, r);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule